// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low-order address bits for a four-beat burst in a synchronous burst memory. A qualified load pulse captures a new address. The low bits become the starting offset of the burst, and the remaining upper bits are held in a register and passed through unchanged. On each later clock edge where the active-low advance input is low, the block steps to the next beat.

A static order-select input chooses the sequence of beats. With the input low, the offset counts upward from the start value and wraps modulo four. With the input high, the offset is the start value XORed with the beat number. The input is meant to be strapped, and high is the default. Strobe arbitration, chip-enable gating and the memory array are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears the start value, the beat count and the upper address, so `ofs_o` and `upper_o` read zero after the reset edge.
- R2: A load captures `addr_i[1:0]` as the start value and restarts the beat count at zero. After that edge, `ofs_o` equals the captured bits.
- R3: A load captures `addr_i` above bit 1 into `upper_o`, which holds its value until the next load.
- R4: When `adv_n_i` is sampled low at an edge with no load, the beat count moves forward by one.
- R5: When `adv_n_i` is sampled high at an edge with no load, the offset and the upper address hold.
- R6: With `order_sel_i` = 0 (linear), `ofs_o` = (start + beat) mod 4. For example, start 2 gives 2,3,0,1.
- R7: With `order_sel_i` = 1 (interleaved), `ofs_o` = start XOR beat. For example, start 1 gives 1,0,3,2.
- R8: A load and an advance on the same edge act as a load only, so the beat count becomes zero.
- R9: An advance after the fourth beat wraps back to the start value instead of stopping.
- R10: A load during a burst discards the current burst and starts again from the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Qualified address load pulse |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_sel_i | input | 1 | Beat order strap: 0 selects linear, 1 selects interleaved |
| addr_i | input | ADDR_W | Address presented with a load |
| ofs_o | output | BEAT_W | Current burst offset |
| upper_o | output | ADDR_W-BEAT_W | Latched upper address |

## Verification
The bench sweeps every start value under both orders and advances past the fourth beat, with hold cycles in between. A counter that saturates, or that wraps to zero instead of to the start value, fails at the fifth beat. Swapping the XOR and the add changes the result only for start values 1 and 3, so both of those are covered. The bench also places a load and an advance on the same edge, and reloads in the middle of a burst, which exposes a wrong priority or a beat count that is not cleared.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [BEAT_W-1:0] start_d_i,
  output logic [BEAT_W-1:0] start_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] start_q, beat_q;
  logic do_load, do_step;

  assign do_load = load_i;
  assign do_step = adv_i && !load_i;

  function automatic logic [BEAT_W-1:0] step_beat(input logic [BEAT_W-1:0] b);
    return b + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (do_load) begin
      start_q <= start_d_i;
      beat_q  <= '0;
    end else if (do_step) begin
      beat_q  <= step_beat(beat_q);
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;

  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_q == '0));
  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !load_i) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> ($stable(beat_q) && $stable(start_q)));
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] ofs_o
);
  function automatic logic [BEAT_W-1:0] lin_ofs(input logic [BEAT_W-1:0] s,
                                                input logic [BEAT_W-1:0] b);
    return s + b;
  endfunction

  function automatic logic [BEAT_W-1:0] ilv_ofs(input logic [BEAT_W-1:0] s,
                                                input logic [BEAT_W-1:0] b);
    return s ^ b;
  endfunction

  always_comb begin
    if (order_i == ORD_LINEAR) ofs_o = lin_ofs(start_i, beat_i);
    else                       ofs_o = ilv_ofs(start_i, beat_i);
  end
endmodule

// File: rtl/burst_hi_latch.sv
module burst_hi_latch #(
  parameter int HI_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [HI_W-1:0] hi_d_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)         hi_q <= '0;
    else if (load_i) hi_q <= hi_d_i;
  end

  assign hi_o = hi_q;

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(hi_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic                     adv_n_i,
  input  logic                     order_sel_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [BEAT_W-1:0]        ofs_o,
  output logic [ADDR_W-BEAT_W-1:0] upper_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              adv_ev;
  logic [BEAT_W-1:0] start_w, beat_w;
  burst_order_e      order_w;

  assign adv_ev  = !adv_n_i;
  assign order_w = burst_order_e'(order_sel_i);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_i(adv_ev),
    .start_d_i(addr_i[BEAT_W-1:0]), .start_o(start_w), .beat_o(beat_w)
  );

  burst_ofs_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i(order_w), .start_i(start_w), .beat_i(beat_w), .ofs_o(ofs_o)
  );

  burst_hi_latch #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .load_i(load_i),
    .hi_d_i(addr_i[ADDR_W-1:BEAT_W]), .hi_o(upper_o)
  );

  // R2
  load_offset_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ofs_o == $past(addr_i[BEAT_W-1:0])));
  // R3
  load_upper_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (upper_o == $past(addr_i[ADDR_W-1:BEAT_W])));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int ADDR_W = 12;
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic clk = 1'b0;
  logic rst, load_i, adv_n_i, order_sel_i;
  logic [ADDR_W-1:0] addr_i;
  logic [BEAT_W-1:0] ofs_o;
  logic [HI_W-1:0]   upper_o;

  int checks = 0, fails = 0, cycles = 0;
  int e_start, e_beat, e_up;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uut (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_sel_i(order_sel_i), .addr_i(addr_i), .ofs_o(ofs_o), .upper_o(upper_o)
  );

  function automatic int exp_ofs();
    if (order_sel_i) return (e_start ^ e_beat) & 3;
    return (e_start + e_beat) % 4;
  endfunction

  task automatic check(string req);
    checks++;
    if (int'(ofs_o) != exp_ofs() || int'(upper_o) != e_up) begin
      fails++;
      $display("FAIL %s: ofs=%0d upper=%0d expected ofs=%0d upper=%0d",
               req, ofs_o, upper_o, exp_ofs(), e_up);
    end
  endtask

  task automatic cyc(input logic ld, input logic advn, input int a, string req);
    @(negedge clk);
    load_i = ld; adv_n_i = advn; addr_i = ADDR_W'(a);
    @(posedge clk);
    if (ld) begin e_start = a & 3; e_beat = 0; e_up = (a >> 2) & ((1 << HI_W) - 1); end
    else if (!advn) e_beat = (e_beat + 1) % 4;
    #1 check(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1; order_sel_i = 1'b1; addr_i = '0;
    e_start = 0; e_beat = 0; e_up = 0;
    @(negedge clk); addr_i = 12'hABF; load_i = 1'b1; adv_n_i = 1'b0;
    @(posedge clk); @(posedge clk); #1 check("R1 reset");
    @(negedge clk); rst = 1'b0; load_i = 1'b0; adv_n_i = 1'b1;
    for (int m = 0; m < 2; m++) begin
      order_sel_i = logic'(m);
      for (int s = 0; s < 4; s++) begin
        int a = (((s * 97) + m * 311 + 5) << 2) | s;
        cyc(1'b1, 1'b1, a, "R2 R3 load");
        for (int k = 0; k < 5; k++)
          cyc(1'b0, 1'b0, 0, m ? "R7 R4 R9 interleaved" : "R6 R4 R9 linear");
        cyc(1'b0, 1'b1, 12'hFFF, "R5 hold");
        cyc(1'b0, 1'b0, 12'h555, "R3 R4 advance after hold");
      end
      cyc(1'b1, 1'b0, 12'h3C6, "R8 load with advance");
      cyc(1'b0, 1'b0, 0, "R8 first advance after");
      cyc(1'b0, 1'b0, 0, "R4 advance");
      cyc(1'b1, 1'b1, 12'h8A3, "R10 mid-burst reload");
      cyc(1'b0, 1'b0, 0, "R10 continue new burst");
      cyc(1'b0, 1'b0, 0, "R10 continue new burst");
    end
    @(negedge clk); rst = 1'b1;
    @(posedge clk); e_start = 0; e_beat = 0; e_up = 0; #1 check("R1 reset mid-run");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule